// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers a set of interrupt lines and presents them to a processor through two independent banks of registers. One bank drives the normal interrupt output and the other drives the fast interrupt output. Each bank holds its own enable mask, its own trigger-mode selection and its own polarity selection. A line can therefore be routed to either output, to both outputs, or to neither, and each bank can treat the same line in a different way.

Each input first passes through a two-stage synchronizer. A line in level mode reports its polarity-adjusted value directly. A line in edge mode sets a sticky pending bit on the chosen edge. That bit stays set until software writes a one to the line's bit in the bank's clear register. Software reaches the registers through a plain 32-bit port with a byte address. Writes take effect on a single-cycle strobe, and reads decode combinationally from the address.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset, the mask, mode and latch state of both banks are zero, the polarity register of both banks reads all ones, and both outputs are low.
- R2: Address bit 5 selects the bank: 0 for the normal bank and 1 for the fast bank. Inside a bank, the word offsets are 0x00 raw, 0x04 mask, 0x08 clear, 0x0C mode and 0x10 polarity, with status at 0x14. Bit n of each register belongs to line n.
- R3: A mask bit of 1 enables its line in that bank. Writing zero to a bank's mask register forces that bank's status to zero on the next cycle.
- R4: A mode bit of 1 makes the line edge-triggered. A mode bit of 0 makes it level-sensitive.
- R5: In level mode, a polarity bit of 1 means active-high and 0 means active-low. In edge mode, 1 selects the rising edge and 0 selects the falling edge.
- R6: An edge event sets the line's pending bit. The bit stays set after the input returns, until a clear write with a one in that bit position. Zero bits in a clear write leave their lines untouched.
- R7: If a clear of a line and a new edge on that same line take effect in the same cycle, the line stays pending.
- R8: Raw reads the pending state before masking, and status reads raw AND mask. The clear register reads as zero. Writes to raw or status change nothing.
- R9: Each output is a registered OR of its own bank's status bits, so it follows status one cycle later. The banks do not affect each other.
- R10: An input change appears in a level-mode raw bit after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 6 | Byte address of the register |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| int_lines | input | 32 | Asynchronous interrupt inputs |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two functions can land on the same clock edge: a software clear of a pending edge line and a fresh edge on that line reaching the detector. The bench raises the line and then counts the synchronizer stages, so that the clear write is strobed exactly on the edge where the detector fires. It then reads raw back and expects the bit still set. A second clear with no edge present must then drop the bit, which shows that the first clear was lost to the edge and not simply ignored.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int unsigned NLINES = 32;
    localparam int unsigned AW     = 6;

    // register selector = byte address bits [4:2]
    localparam logic [2:0] SEL_RAW  = 3'd0;
    localparam logic [2:0] SEL_MASK = 3'd1;
    localparam logic [2:0] SEL_CLR  = 3'd2;
    localparam logic [2:0] SEL_MODE = 3'd3;
    localparam logic [2:0] SEL_POL  = 3'd4;
    localparam logic [2:0] SEL_STAT = 3'd5;

    typedef struct packed {
        logic [NLINES-1:0] mask;
        logic [NLINES-1:0] mode;
        logic [NLINES-1:0] pol;
        logic [NLINES-1:0] latch;
        logic              intr;
    } bank_state_t;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
        logic [W-1:0] prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.meta = async_in;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.sync;
    assign prev_o = st_q.prev;
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int unsigned N = NLINES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_sel,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] lvl_in,
    input  logic [N-1:0] prev_in,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] mode_o,
    output logic [N-1:0] pol_o,
    output logic [N-1:0] status_o,
    output logic         intr_o
);
    typedef struct packed {
        logic [N-1:0] mask;
        logic [N-1:0] mode;
        logic [N-1:0] pol;
        logic [N-1:0] latch;
        logic         intr;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] evt_vec, clr_vec, raw_vec, stat_vec;

    always_comb begin
        // edge event per line: rising when pol=1, falling when pol=0
        evt_vec  = st_q.mode & ((st_q.pol & lvl_in & ~prev_in) |
                                (~st_q.pol & ~lvl_in & prev_in));
        clr_vec  = (wr_en && wr_sel == SEL_CLR) ? wdata : '0;
        raw_vec  = (st_q.mode & st_q.latch) |
                   (~st_q.mode & ~(lvl_in ^ st_q.pol));
        stat_vec = raw_vec & st_q.mask;

        st_d       = st_q;
        st_d.latch = (st_q.latch & ~clr_vec) | evt_vec;
        st_d.intr  = |stat_vec;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_MASK: st_d.mask = wdata;
                SEL_MODE: st_d.mode = wdata;
                SEL_POL:  st_d.pol  = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pol  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o    = raw_vec;
    assign mask_o   = st_q.mask;
    assign mode_o   = st_q.mode;
    assign pol_o    = st_q.pol;
    assign status_o = stat_vec;
    assign intr_o   = st_q.intr;

    // R6: a cleared line with no new event is no longer latched
    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CLR) |=> ((st_q.latch & $past(wdata & ~evt_vec)) == '0));

    // R7: a detected edge is always latched, even under a simultaneous clear
    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec != '0) |=> ((st_q.latch & $past(evt_vec)) == $past(evt_vec)));

    // R3: a zero mask write silences the bank's status on the next cycle
    assert_mask_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_MASK && wdata == '0) |=> (stat_vec == '0));

    // R9: the output is low one cycle after status was empty
    assert_out_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vec == '0) |=> !intr_o);
endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NLINES-1:0] int_lines,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int unsigned NB = 2;

    logic [NLINES-1:0] lvl, prev;
    logic [NLINES-1:0] raw_b [NB];
    logic [NLINES-1:0] msk_b [NB];
    logic [NLINES-1:0] mod_b [NB];
    logic [NLINES-1:0] pol_b [NB];
    logic [NLINES-1:0] sts_b [NB];
    logic [NB-1:0]     intr_b;
    logic [2:0]        sel;
    logic              bsel;

    assign sel  = reg_addr[4:2];
    assign bsel = reg_addr[5];

    intc_sync #(.W(NLINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(int_lines),
        .sync_o(lvl), .prev_o(prev)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        intc_bank #(.N(NLINES)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .wr_en(reg_wr && (bsel == b[0])),
            .wr_sel(sel), .wdata(reg_wdata),
            .lvl_in(lvl), .prev_in(prev),
            .raw_o(raw_b[b]), .mask_o(msk_b[b]), .mode_o(mod_b[b]),
            .pol_o(pol_b[b]), .status_o(sts_b[b]), .intr_o(intr_b[b])
        );
    end

    always_comb begin
        unique case (sel)
            SEL_RAW:  reg_rdata = raw_b[bsel];
            SEL_MASK: reg_rdata = msk_b[bsel];
            SEL_MODE: reg_rdata = mod_b[bsel];
            SEL_POL:  reg_rdata = pol_b[bsel];
            SEL_STAT: reg_rdata = sts_b[bsel];
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_o = intr_b[0];
    assign fiq_o = intr_b[1];

    // R8: the clear register always reads as zero
    assert_clear_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CLR) |-> (reg_rdata == '0));
endmodule

// File: tb/sim_intc_dual_bank.sv
module sim_intc_dual_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] int_lines = '0;
    logic        irq_o, fiq_o;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    intc_dual_bank u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_lines(int_lines),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(6'h04, v); check("R1 irq mask", v, 32'h0);
        rd(6'h0C, v); check("R1 irq mode", v, 32'h0);
        rd(6'h30, v); check("R1 fiq pol", v, 32'hFFFF_FFFF);
        rd(6'h14, v); check("R1 irq status", v, 32'h0);
        check("R1 outputs", {30'b0, irq_o, fiq_o}, 32'h0);
    endtask

    task automatic t_sync_latency();
        logic [31:0] v;
        wr(6'h04, 32'h0000_0001);
        int_lines[0] = 1'b1;
        @(negedge clk);
        rd(6'h00, v); check("R10 raw after one edge", v & 32'h1, 32'h0);
        @(negedge clk);
        rd(6'h00, v); check("R10 raw after two edges", v & 32'h1, 32'h1);
        check("R9 irq still low", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R9 irq registered", {31'b0, irq_o}, 32'h1);
        check("R9 fiq untouched", {31'b0, fiq_o}, 32'h0);
        int_lines[0] = 1'b0;
        wait_cyc(4);
        check("R4 level follows input", {31'b0, irq_o}, 32'h0);
        wr(6'h04, 32'h0);
    endtask

    task automatic t_level_polarity();
        logic [31:0] v;
        wr(6'h04, 32'h0000_0008);
        wr(6'h10, ~32'h0000_0008);
        wait_cyc(3);
        rd(6'h00, v); check("R5 active-low raw", v & 32'h8, 32'h8);
        check("R3 irq with enabled low line", {31'b0, irq_o}, 32'h1);
        int_lines[3] = 1'b1;
        wait_cyc(4);
        rd(6'h14, v); check("R5 active-low inactive", v, 32'h0);
        wr(6'h10, 32'hFFFF_FFFF);
        int_lines[3] = 1'b0;
        wr(6'h04, 32'h0);
    endtask

    task automatic t_edge_latch();
        logic [31:0] v;
        wr(6'h0C, 32'h0000_0020);
        wr(6'h04, 32'h0000_0020);
        int_lines[5] = 1'b1; wait_cyc(4);
        int_lines[5] = 1'b0; wait_cyc(4);
        rd(6'h00, v); check("R6 rising edge held", v & 32'h20, 32'h20);
        check("R9 irq from latch", {31'b0, irq_o}, 32'h1);
        wr(6'h08, 32'hFFFF_FFDF);
        rd(6'h00, v); check("R6 zero clear bit no effect", v & 32'h20, 32'h20);
        wr(6'h08, 32'h0000_0020);
        rd(6'h00, v); check("R6 cleared", v & 32'h20, 32'h0);
        @(negedge clk);
        check("R9 irq drops", {31'b0, irq_o}, 32'h0);
        // falling edge selection
        int_lines[5] = 1'b1; wait_cyc(4);
        wr(6'h08, 32'h0000_0020);
        wr(6'h10, ~32'h0000_0020);
        wait_cyc(2);
        rd(6'h00, v); check("R5 no event on polarity change", v & 32'h20, 32'h0);
        int_lines[5] = 1'b0; wait_cyc(4);
        rd(6'h00, v); check("R5 falling edge latched", v & 32'h20, 32'h20);
        wr(6'h08, 32'h0000_0020);
        wr(6'h10, 32'hFFFF_FFFF);
        wr(6'h0C, 32'h0);
        wr(6'h04, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(6'h0C, 32'h0000_0040);
        int_lines[6] = 1'b1; wait_cyc(4);
        int_lines[6] = 1'b0; wait_cyc(4);
        rd(6'h00, v); check("R7 setup pending", v & 32'h40, 32'h40);
        int_lines[6] = 1'b1;       // before posedge 1
        @(negedge clk);            // after posedge 1
        @(negedge clk);            // after posedge 2: edge visible to detector
        reg_addr = 6'h08; reg_wdata = 32'h0000_0040; reg_wr = 1'b1;
        @(negedge clk);            // posedge 3: clear and edge together
        reg_wr = 1'b0;
        rd(6'h00, v); check("R7 edge wins over clear", v & 32'h40, 32'h40);
        wr(6'h08, 32'h0000_0040);
        rd(6'h00, v); check("R7 plain clear works", v & 32'h40, 32'h0);
        int_lines[6] = 1'b0;
        wr(6'h0C, 32'h0);
    endtask

    task automatic t_fiq_bank();
        logic [31:0] v;
        wr(6'h24, 32'h0000_0100);
        int_lines[8] = 1'b1; wait_cyc(4);
        check("R2 fiq bank drives fiq", {31'b0, fiq_o}, 32'h1);
        check("R9 irq independent", {31'b0, irq_o}, 32'h0);
        rd(6'h34, v); check("R2 fiq status offset", v, 32'h0000_0100);
        rd(6'h14, v); check("R9 irq status unaffected", v, 32'h0);
        wr(6'h00, 32'hFFFF_FFFF);
        wr(6'h34, 32'hFFFF_FFFF);
        rd(6'h20, v); check("R8 raw write ignored", v, 32'h0000_0100);
        rd(6'h28, v); check("R8 clear reads zero", v, 32'h0);
        rd(6'h0C, v); check("R8 mode untouched", v, 32'h0);
        wr(6'h24, 32'h0);
        rd(6'h34, v); check("R3 zero mask disables", v, 32'h0);
        @(negedge clk);
        check("R3 fiq drops", {31'b0, fiq_o}, 32'h0);
        int_lines[8] = 1'b0;
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sync_latency();
        t_level_polarity();
        t_edge_latch();
        t_collide();
        t_fiq_bank();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule